// File: doc/BRIEF.md
# Maskable Interrupt Cause Register

This block gathers single-cycle event pulses from the transmit, receive, link and management logic of a network controller. It holds each event as a sticky pending bit and raises one interrupt line while any pending bit is also enabled. Software reaches the block over a simple register bus with an address, a write strobe with data, and a read strobe with combinational read data. There are four register offsets. One returns the pending causes and empties them. One lets software inject causes for testing. Two more set and clear the enable mask bit by bit.

The cause bits sit at fixed positions that driver software decodes. Bit 0 means a transmit descriptor was written back. Bit 1 means the transmit queue emptied. Bit 2 means the link state changed. Bit 3 is a receive sequence error. Bit 4 means the receive descriptors fell to their minimum threshold. Bit 6 is a receive overrun and bit 7 is the receive timer. Bit 9 means a management access finished. Bit 10 means configuration ordered sets were received. Bit 11 is general-purpose input 0. Bit positions 5, 8 and everything above 11 are not implemented.

Top module: `irq_cause_ctrl`

## Requirements
- R1: Reset (rst_n low) empties all pending causes and the mask, so irq_o is low and every register reads zero.
- R2: A high evt_i bit at an implemented position (0, 1, 2, 3, 4, 6, 7, 9, 10, 11) sets the pending cause at that bit after the next rising clock edge. Positions 5, 8 and 12 and above never become pending and always read zero.
- R3: A pending cause stays set, however long it waits, until the cause register at offset 0xC0 is read.
- R4: A read at offset 0xC0 returns the pending causes in the same cycle and clears them at the clock edge. An event that arrives in that same cycle stays pending afterwards.
- R5: Writing offset 0xC8 ORs the written ones into the pending causes at implemented positions. Zero bits leave pending causes untouched.
- R6: Writing offset 0xD0 enables each cause whose written bit is 1 and leaves the other enables unchanged. A read at 0xD0 returns the current mask.
- R7: Writing offset 0xD8 disables each cause whose written bit is 1. Writing all ones disables every cause. Pending causes are not affected.
- R8: irq_o is high exactly when some cause is both pending and enabled. It follows register changes after the clock edge that makes them.
- R9: Reads at 0xC8, 0xD8 or any unmapped offset return zero and clear nothing. Writes to 0xC0 or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 12 | Event pulses, one bit per cause position |
| bus_addr | input | ADDR_W (16) | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe; a read at 0xC0 clears the causes |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
Events are applied as a full-width burst, as single bits, and as a pulse in the same cycle as a clearing read. This separates a plain sticky set from the read-versus-event race and exposes any leak of unimplemented positions. Causes are also injected through the set offset, with patterns that include zero bits and unimplemented bits. Mask writes mix ones and zeros so that a true bitwise set or clear can be told apart from a whole-register load. irq_o is observed with a cause that is pending but masked, then unmasked, then masked again. This shows that the mask gates the line without touching the pending bits. Reads and writes at the non-clearing and unmapped offsets confirm that they have no side effects.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CAUSE_W = 12;

  // cause bit positions decoded by driver software
  localparam int CB_TX_DONE   = 0;
  localparam int CB_TXQ_EMPTY = 1;
  localparam int CB_LINK_CHG  = 2;
  localparam int CB_RX_SEQ    = 3;
  localparam int CB_RX_LOW    = 4;
  localparam int CB_RX_OVR    = 6;
  localparam int CB_RX_TMR    = 7;
  localparam int CB_MGMT_DONE = 9;
  localparam int CB_CFG_SEEN  = 10;
  localparam int CB_GPI0      = 11;

  localparam logic [CAUSE_W-1:0] CAUSE_IMPL =
    CAUSE_W'((1 << CB_TX_DONE) | (1 << CB_TXQ_EMPTY) | (1 << CB_LINK_CHG) |
             (1 << CB_RX_SEQ) | (1 << CB_RX_LOW) | (1 << CB_RX_OVR) |
             (1 << CB_RX_TMR) | (1 << CB_MGMT_DONE) | (1 << CB_CFG_SEEN) |
             (1 << CB_GPI0));

  // register offsets
  localparam int OFS_CAUSE_RD = 'hC0;
  localparam int OFS_CAUSE_WR = 'hC8;
  localparam int OFS_MASK_SET = 'hD0;
  localparam int OFS_MASK_CLR = 'hD8;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         set_en,
  input  logic [W-1:0] set_bits,
  input  logic         clr_en,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q, pend_d;
  logic         pend_en;

  always_comb begin
    pend_d = clr_en ? '0 : pend_q;
    pend_d = pend_d | evt_i | (set_en ? set_bits : '0);
    pend_en = clr_en | set_en | (|evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_mask.sv
module irq_mask #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits_i,
  input  logic [W-1:0] impl_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;
  logic         mask_en;

  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_d | (bits_i & impl_i);
    if (clr_en) mask_d = mask_d & ~bits_i;
    mask_en = set_en | clr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] evt_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(CAUSE_IMPL);

  logic              rst_ns;
  logic              hit_crd, hit_cwr, hit_mset, hit_mclr;
  logic [DATA_W-1:0] evt_w, pend_q, mask_q;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  always_comb begin
    hit_crd  = (bus_addr == ADDR_W'(OFS_CAUSE_RD));
    hit_cwr  = (bus_addr == ADDR_W'(OFS_CAUSE_WR));
    hit_mset = (bus_addr == ADDR_W'(OFS_MASK_SET));
    hit_mclr = (bus_addr == ADDR_W'(OFS_MASK_CLR));
    evt_w    = DATA_W'(evt_i) & IMPL;
  end

  irq_pend #(.W(DATA_W)) u_pend (
    .clk(clk), .rst_n(rst_ns), .evt_i(evt_w),
    .set_en(bus_wr & hit_cwr), .set_bits(bus_wdata & IMPL),
    .clr_en(bus_rd & hit_crd), .pend_o(pend_q)
  );

  irq_mask #(.W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_ns),
    .set_en(bus_wr & hit_mset), .clr_en(bus_wr & hit_mclr),
    .bits_i(bus_wdata), .impl_i(IMPL), .mask_o(mask_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_crd)       bus_rdata = pend_q;
      else if (hit_mset) bus_rdata = mask_q;
    end
  end

  assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ns,
  input logic [11:0]       evt_i,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] pend,
  input logic [DATA_W-1:0] mask,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(irq_pkg::CAUSE_IMPL);
  logic [DATA_W-1:0] ev;
  logic rd_c, wr_s, wr_ms, wr_mc;
  assign ev    = DATA_W'(evt_i) & IMPL;
  assign rd_c  = bus_rd && bus_addr == ADDR_W'('hC0);
  assign wr_s  = bus_wr && bus_addr == ADDR_W'('hC8);
  assign wr_ms = bus_wr && bus_addr == ADDR_W'('hD0);
  assign wr_mc = bus_wr && bus_addr == ADDR_W'('hD8);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (|ev) |=> ((pend & $past(ev)) == $past(ev)));
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_c |=> ((pend & $past(pend)) == $past(pend)));
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_c && !wr_s && ev == '0) |=> (pend == '0));
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_ms |=> ((mask & $past(bus_wdata & IMPL)) == $past(bus_wdata & IMPL)));
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    !(wr_ms || wr_mc) |=> $stable(mask));
  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_mc |=> ((mask & $past(bus_wdata)) == '0));
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_mc && bus_wdata == '1) |=> !irq_o);
  p_quiet_reads_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_rd && !rd_c && bus_addr != ADDR_W'('hD0)) |-> bus_rdata == '0);
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .evt_i(evt_i), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .pend(pend_q), .mask(mask_q), .irq_o(irq_o)
);

// File: tb/sim_irq_cause_ctrl.sv
module sim_irq_cause_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt_i = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  irq_cause_ctrl u0 (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd('hD0, d); check("R1 mask", d, 32'h0);
    rd('hC0, d); check("R1 cause", d, 32'h0);
    wr('hD0, 32'hFFF); wr('hC8, 32'hFFF);
    do_reset();
    check("R1 irq after rearm", {31'b0, irq_o}, 32'h0);
    rd('hD0, d); check("R1 mask after rearm", d, 32'h0);
    rd('hC0, d); check("R1 cause after rearm", d, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(12'hFFF);
    rd('hC0, d); check("R2 all events, gaps 5 and 8 empty", d, 32'h0000_0EDF);
    pulse(12'h040);
    rd('hC0, d); check("R2 overrun bit 6", d, 32'h40);
    pulse(12'h120);
    rd('hC0, d); check("R2 unimplemented 5 and 8", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(12'h004);
    repeat (6) @(negedge clk);
    rd('hD0, d);
    rd('hC0, d); check("R3 link change held", d, 32'h4);
    rd('hC0, d); check("R4 cleared by read", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(12'h001);
    @(negedge clk); bus_addr = 'hC0; bus_rd = 1'b1; evt_i = 12'h200;
    #2 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; evt_i = '0;
    check("R4 read value", d, 32'h1);
    rd('hC0, d); check("R4 event during read kept", d, 32'h200);
  endtask

  task automatic t_cause_set();
    logic [31:0] d;
    wr('hC8, 32'h0000_0881);
    wr('hC8, 32'h0000_0000);
    rd('hC0, d); check("R5 injected causes", d, 32'h881);
    wr('hC8, 32'h8000_0120);
    rd('hC0, d); check("R5 unimplemented injection", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr('hD0, 32'h5); wr('hD0, 32'h2);
    rd('hD0, d); check("R6 bitwise set", d, 32'h7);
    wr('hD8, 32'h4);
    rd('hD0, d); check("R7 bitwise clear", d, 32'h3);
    wr('hD8, 32'hFFFF_FFFF);
    rd('hD0, d); check("R7 clear all", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr('hC8, 32'h2);
    check("R8 masked pending low", {31'b0, irq_o}, 32'h0);
    wr('hD0, 32'h2);
    check("R8 unmask raises", {31'b0, irq_o}, 32'h1);
    wr('hD8, 32'h2);
    check("R8 mask lowers", {31'b0, irq_o}, 32'h0);
    rd('hC0, d); check("R7 mask keeps pending", d, 32'h2);
    wr('hD0, 32'h8); pulse(12'h008);
    check("R8 event raises", {31'b0, irq_o}, 32'h1);
    rd('hC0, d);
    check("R8 read lowers", {31'b0, irq_o}, 32'h0);
    wr('hD8, 32'hFFFF_FFFF);
  endtask

  task automatic t_quiet();
    logic [31:0] d;
    wr('hC8, 32'h10); wr('hD0, 32'h10);
    rd('hC8, d); check("R9 set offset reads zero", d, 32'h0);
    rd('hD8, d); check("R9 clear offset reads zero", d, 32'h0);
    rd('h00, d); check("R9 unmapped reads zero", d, 32'h0);
    wr('hC0, 32'hFFF); wr('h1C0, 32'hFFF);
    check("R9 irq still high", {31'b0, irq_o}, 32'h1);
    rd('hD0, d); check("R9 mask untouched", d, 32'h10);
    rd('hC0, d); check("R9 causes untouched", d, 32'h10);
  endtask

  initial begin
    t_reset();
    t_events();
    t_sticky();
    t_race();
    t_cause_set();
    t_mask();
    t_irq();
    t_quiet();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule